// File: doc/BRIEF.md
# Fixed-Point Tip-Height PI Controller

This block closes the height loop of a tunnelling probe in the digital domain. Each incoming sample is a signed reading of the amplified tip current. The block subtracts an operator setpoint from it to form an error and can flip the sign of that error, so that the loop stays negative feedback whatever the bias polarity. A programmable proportional gain scales the error. A first-order low-pass, placed well below the scanner's mechanical resonance, then smooths it, and a trapezoidal integrator with a selectable time constant accumulates the result. The integrator value is added to a Z offset word and to a scan-slope term built from two signed coefficients and the current scan coordinates. The sum is multiplied by ten and clamped to a signed Z drive word.

Samples enter on a valid/ready stream, and results leave on a second valid/ready stream. One output register sits between the two streams. A sample is accepted when `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. While `m_valid` is high and `m_ready` is low, the result is held unchanged and no new sample is taken. The control words (setpoint, gains, offset, slope, mode bits) are plain levels, and the block reads them in the cycle a sample is accepted. The integrator clear is the one exception: it acts in any cycle.

Top module: `tip_pi_ctrl`

## Requirements
- R1: A sample accepted at a clock edge produces `m_valid`=1 with its result from that edge on. While `m_valid`=1 and `m_ready`=0, `s_ready` is 0 and `m_z`/`m_integ` do not change.
- R2: The error is `s_meas − setpoint`, negated when `pol_inv`=1. With `pol_inv`=0 and the measurement held above the setpoint, the integrator and Z rise. A positive Z means retract.
- R3: The proportional value is p = floor(e·kp/64), with `kp` an unsigned 8-bit code. Codes 6 to 134 span gains of about 0.1 to 2.1, and kp=0 keeps the integrator at zero.
- R4: The low-pass is y = sat20(floor((A·(p+p₋₁) + B·y₋₁)/2^15)). Here wT = floor(2·355·FC·2^15/(113·FS)), A = floor(wT·2^15/(2^16+wT)) and B = 2^15 − 2A. The defaults are FS=100000 and FC=1600.
- R5: The integrator is I = sat16(I₋₁ + floor((y+y₋₁)/2^(t+1))), where t is `tc_sel` clamped to 10. With FS=100 kHz this gives time constants from 10 µs to about 10 ms.
- R6: The integrator saturates at 32767 and −32768 and never wraps.
- R7: The slope term is floor((kx·X + ky·Y)/4096), using `slope_kx`, `slope_ky`, `scan_x` and `scan_y`.
- R8: `m_z` = sat16(10·(I + `z_offset` + slope)), and `m_integ` = I.
- R9: With `hold`=1 and the loop on, the integrator keeps its value while the filter state still advances.
- R10: With `loop_en`=0, an accepted sample clears the filter and integrator state. That result has `m_integ`=0 and Z built from the offset and the slope only.
- R11: `int_clr` sets the integrator to zero. On an accepted sample it takes priority over hold and accumulation, so that result has `m_integ`=0.
- R12: After reset, `m_valid`=0, `s_ready`=1, `m_z`=0, `m_integ`=0, and all filter and integrator state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Current sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_meas | input | 16 | Signed current reading |
| setpoint | input | 16 | Signed target current |
| kp | input | 8 | Proportional gain, unsigned, 6 fraction bits |
| tc_sel | input | 4 | Integrator time-constant select |
| pol_inv | input | 1 | Invert error sign |
| loop_en | input | 1 | Feedback loop closed when 1 |
| hold | input | 1 | Freeze integrator |
| int_clr | input | 1 | Clear integrator |
| z_offset | input | 16 | Signed Z offset word |
| slope_kx | input | 16 | Signed X slope coefficient, 12 fraction bits |
| slope_ky | input | 16 | Signed Y slope coefficient, 12 fraction bits |
| scan_x | input | 16 | Signed scan X coordinate |
| scan_y | input | 16 | Signed scan Y coordinate |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Consumer takes result |
| m_z | output | 16 | Signed Z drive word |
| m_integ | output | 16 | Signed integrator value for recording |

## Verification
The properties assume that the consumer obeys the handshake and that `int_clr` is raised only together with an accepted sample or while the output is idle. A pulse of `int_clr` during a stall would clear the state behind a held result. The bench raises the clear only on the cycle in which a sample is taken, and it keeps every control word steady for as long as a sample waits. It draws errors within a few thousand counts of the setpoint and drives gains, slopes and offsets over their full ranges. This reaches both the saturation bounds and the mid-range arithmetic.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam longint PI_NUM = 355;
  localparam longint PI_DEN = 113;

  typedef enum logic {POL_NORMAL = 1'b0, POL_INVERT = 1'b1} pol_e;

  // Normalised angular step omega*T, scaled by 2^frac.
  function automatic longint wt_scaled(longint fs, longint fc, int frac);
    return (2 * PI_NUM * fc * (longint'(1) << frac)) / (PI_DEN * fs);
  endfunction

  // Bilinear low-pass input coefficient wT/(2+wT), scaled by 2^frac.
  function automatic longint lp_coef_a(longint fs, longint fc, int frac);
    longint wt;
    wt = wt_scaled(fs, fc, frac);
    return (wt << frac) / ((longint'(2) << frac) + wt);
  endfunction
endpackage

// File: rtl/tpc_prop_lp.sv
module tpc_prop_lp
  import tpc_pkg::*;
#(
  parameter int     W       = 16,
  parameter int     KPW     = 8,
  parameter int     KP_FRAC = 6,
  parameter int     CF      = 15,
  parameter longint FS      = 100000,
  parameter longint FC      = 1600,
  parameter int     PW      = W + KPW + 2 - KP_FRAC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 clr,
  input  logic signed [W-1:0]  meas,
  input  logic signed [W-1:0]  setpoint,
  input  logic [KPW-1:0]       kp,
  input  logic                 pol_inv,
  output logic signed [PW-1:0] y,
  output logic signed [PW-1:0] y_prev
);
  localparam longint A_L = lp_coef_a(FS, FC, CF);
  localparam longint B_L = (longint'(1) << CF) - 2 * A_L;
  localparam int     AW  = PW + CF + 4;
  localparam int     MW  = W + KPW + 2;
  localparam logic signed [AW-1:0] COEF_A = AW'(A_L);
  localparam logic signed [AW-1:0] COEF_B = AW'(B_L);
  localparam logic signed [AW-1:0] PMAX   = AW'((longint'(1) << (PW - 1)) - 1);
  localparam logic signed [AW-1:0] PMIN   = -AW'(longint'(1) << (PW - 1));

  pol_e                 pol;
  logic signed [W:0]    err, err_pol;
  logic signed [MW-1:0] prod;
  logic signed [PW-1:0] p, p_prev;
  logic signed [PW:0]   psum;
  logic signed [AW-1:0] acc, acc_sh;

  assign pol = pol_e'(pol_inv);

  always_comb begin
    err     = (W+1)'(meas) - (W+1)'(setpoint);
    err_pol = (pol == POL_INVERT) ? -err : err;
    prod    = MW'(err_pol) * MW'($signed({1'b0, kp}));
    p       = PW'(prod >>> KP_FRAC);
    psum    = (PW+1)'(p) + (PW+1)'(p_prev);
    acc     = AW'(psum) * COEF_A + AW'(y_prev) * COEF_B;
    acc_sh  = acc >>> CF;
    if (acc_sh > PMAX)      y = PW'(PMAX);
    else if (acc_sh < PMIN) y = PW'(PMIN);
    else                    y = PW'(acc_sh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_prev <= '0;
      y_prev <= '0;
    end else if (clr) begin
      p_prev <= '0;
      y_prev <= '0;
    end else if (adv) begin
      p_prev <= p;
      y_prev <= y;
    end
  end
endmodule

// File: rtl/tpc_integ.sv
module tpc_integ #(
  parameter int W      = 16,
  parameter int PW     = 20,
  parameter int TCW    = 4,
  parameter int TC_MAX = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 clr,
  input  logic                 hold,
  input  logic signed [PW-1:0] y,
  input  logic signed [PW-1:0] y_prev,
  input  logic [TCW-1:0]       tc,
  output logic signed [W-1:0]  i_next,
  output logic signed [W-1:0]  i_q
);
  localparam int IW = PW + 2;
  localparam logic signed [IW-1:0] IMAX = IW'((longint'(1) << (W - 1)) - 1);
  localparam logic signed [IW-1:0] IMIN = -IW'(longint'(1) << (W - 1));

  logic [TCW-1:0]       tcc;
  logic [TCW:0]         shamt;
  logic signed [PW:0]   ysum, inc;
  logic signed [IW-1:0] isum;
  logic signed [W-1:0]  i_upd;

  always_comb begin
    tcc   = (tc > TCW'(TC_MAX)) ? TCW'(TC_MAX) : tc;
    shamt = {1'b0, tcc} + 1'b1;
    ysum  = (PW+1)'(y) + (PW+1)'(y_prev);
    inc   = ysum >>> shamt;
    isum  = IW'(i_q) + IW'(inc);
    if (isum > IMAX)      i_upd = W'(IMAX);
    else if (isum < IMIN) i_upd = W'(IMIN);
    else                  i_upd = W'(isum);
    if (clr)       i_next = '0;
    else if (hold) i_next = i_q;
    else           i_next = i_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   i_q <= '0;
    else if (clr) i_q <= '0;
    else if (adv) i_q <= i_next;
  end
endmodule

// File: rtl/tpc_zmix.sv
module tpc_zmix #(
  parameter int W     = 16,
  parameter int SF    = 12,
  parameter int ZGAIN = 10
) (
  input  logic signed [W-1:0] integ,
  input  logic signed [W-1:0] zoff,
  input  logic signed [W-1:0] kx,
  input  logic signed [W-1:0] ky,
  input  logic signed [W-1:0] sx,
  input  logic signed [W-1:0] sy,
  output logic signed [W-1:0] z
);
  localparam int SW  = 2 * W + 2;
  localparam int GW  = $clog2(ZGAIN + 1) + 1;
  localparam int SCW = SW + GW;
  localparam logic signed [SCW-1:0] GAIN_C = SCW'(ZGAIN);
  localparam logic signed [SCW-1:0] ZMAX   = SCW'((longint'(1) << (W - 1)) - 1);
  localparam logic signed [SCW-1:0] ZMIN   = -SCW'(longint'(1) << (W - 1));

  logic signed [SW-1:0]  slope_raw, slope, total;
  logic signed [SCW-1:0] scaled;

  always_comb begin
    slope_raw = SW'(kx) * SW'(sx) + SW'(ky) * SW'(sy);
    slope     = slope_raw >>> SF;
    total     = SW'(integ) + SW'(zoff) + slope;
    scaled    = SCW'(total) * GAIN_C;
    if (scaled > ZMAX)      z = W'(ZMAX);
    else if (scaled < ZMIN) z = W'(ZMIN);
    else                    z = W'(scaled);
  end
endmodule

// File: rtl/tip_pi_ctrl.sv
module tip_pi_ctrl #(
  parameter int     W       = 16,
  parameter int     KPW     = 8,
  parameter int     KP_FRAC = 6,
  parameter int     CF      = 15,
  parameter longint FS      = 100000,
  parameter longint FC      = 1600,
  parameter int     TCW     = 4,
  parameter int     TC_MAX  = 10,
  parameter int     SF      = 12,
  parameter int     ZGAIN   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic signed [W-1:0] s_meas,
  input  logic signed [W-1:0] setpoint,
  input  logic [KPW-1:0]      kp,
  input  logic [TCW-1:0]      tc_sel,
  input  logic                pol_inv,
  input  logic                loop_en,
  input  logic                hold,
  input  logic                int_clr,
  input  logic signed [W-1:0] z_offset,
  input  logic signed [W-1:0] slope_kx,
  input  logic signed [W-1:0] slope_ky,
  input  logic signed [W-1:0] scan_x,
  input  logic signed [W-1:0] scan_y,
  output logic                m_valid,
  input  logic                m_ready,
  output logic signed [W-1:0] m_z,
  output logic signed [W-1:0] m_integ
);
  localparam int PW = W + KPW + 2 - KP_FRAC;

  logic                 accept, loop_off_clr, integ_clr;
  logic signed [PW-1:0] lp_y, lp_y_prev;
  logic signed [W-1:0]  integ_next, integ_q, z_next;

  assign s_ready      = !m_valid || m_ready;
  assign accept       = s_valid && s_ready;
  assign loop_off_clr = accept && !loop_en;
  assign integ_clr    = int_clr || loop_off_clr;

  tpc_prop_lp #(
    .W(W), .KPW(KPW), .KP_FRAC(KP_FRAC), .CF(CF), .FS(FS), .FC(FC), .PW(PW)
  ) u_prop (
    .clk(clk), .rst_n(rst_n), .adv(accept), .clr(loop_off_clr),
    .meas(s_meas), .setpoint(setpoint), .kp(kp), .pol_inv(pol_inv),
    .y(lp_y), .y_prev(lp_y_prev)
  );

  tpc_integ #(.W(W), .PW(PW), .TCW(TCW), .TC_MAX(TC_MAX)) u_integ (
    .clk(clk), .rst_n(rst_n), .adv(accept), .clr(integ_clr), .hold(hold),
    .y(lp_y), .y_prev(lp_y_prev), .tc(tc_sel),
    .i_next(integ_next), .i_q(integ_q)
  );

  tpc_zmix #(.W(W), .SF(SF), .ZGAIN(ZGAIN)) u_zmix (
    .integ(integ_next), .zoff(z_offset), .kx(slope_kx), .ky(slope_ky),
    .sx(scan_x), .sy(scan_y), .z(z_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_z     <= '0;
      m_integ <= '0;
    end else begin
      if (accept) begin
        m_valid <= 1'b1;
        m_z     <= z_next;
        m_integ <= integ_next;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tpc_chk.sv
module tpc_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                s_valid,
  input logic                s_ready,
  input logic                m_valid,
  input logic                m_ready,
  input logic                loop_en,
  input logic                hold,
  input logic                int_clr,
  input logic signed [W-1:0] m_z,
  input logic signed [W-1:0] m_integ,
  input logic signed [W-1:0] integ_q
);
  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_z) && $stable(m_integ)));

  // R1
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);

  // R1
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  // R10
  loop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !loop_en) |=> (m_integ == '0));

  // R11
  int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && int_clr) |=> (m_integ == '0));

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && loop_en && hold && !int_clr) |=> (m_integ == $past(integ_q)));
endmodule

bind tip_pi_ctrl tpc_chk #(.W(W)) u_tpc_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .loop_en(loop_en), .hold(hold),
  .int_clr(int_clr), .m_z(m_z), .m_integ(m_integ), .integ_q(integ_q)
);

// File: tb/tb_tip_pi_ctrl.sv
module tb_tip_pi_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_ready, m_valid, m_ready = 1'b1;
  logic signed [15:0] s_meas = '0, setpoint = '0, z_offset = '0;
  logic signed [15:0] slope_kx = '0, slope_ky = '0, scan_x = '0, scan_y = '0;
  logic [7:0] kp = '0;
  logic [3:0] tc_sel = '0;
  logic pol_inv = 1'b0, loop_en = 1'b0, hold = 1'b0, int_clr = 1'b0;
  logic signed [15:0] m_z, m_integ;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tip_pi_ctrl dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_meas(s_meas), .setpoint(setpoint), .kp(kp), .tc_sel(tc_sel),
    .pol_inv(pol_inv), .loop_en(loop_en), .hold(hold), .int_clr(int_clr),
    .z_offset(z_offset), .slope_kx(slope_kx), .slope_ky(slope_ky),
    .scan_x(scan_x), .scan_y(scan_y), .m_valid(m_valid), .m_ready(m_ready),
    .m_z(m_z), .m_integ(m_integ)
  );

  // Filter coefficients per R4
  localparam longint WT = (2 * 355 * 1600 * 32768) / (113 * 100000);
  localparam longint CA = (WT * 32768) / (65536 + WT);
  localparam longint CB = 32768 - 2 * CA;

  longint mp = 0, my = 0, mi = 0;

  function automatic longint sat(longint v, int w);
    longint lim = longint'(1) << (w - 1);
    if (v > lim - 1) return lim - 1;
    if (v < -lim) return -lim;
    return v;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected result for the current inputs (R2..R11)
  task automatic model(output longint ez, output longint ei);
    longint slope, e, p, y, tcc, inc, ni;
    slope = (longint'(slope_kx) * scan_x + longint'(slope_ky) * scan_y) >>> 12;
    if (!loop_en) begin
      mp = 0; my = 0; mi = 0; ei = 0;
    end else begin
      e = longint'(s_meas) - longint'(setpoint);
      if (pol_inv) e = -e;
      p = (e * longint'(kp)) >>> 6;
      y = sat((CA * (p + mp) + CB * my) >>> 15, 20);
      tcc = (tc_sel > 10) ? 10 : longint'(tc_sel);
      inc = (y + my) >>> (tcc + 1);
      if (int_clr) ni = 0;
      else if (hold) ni = mi;
      else ni = sat(mi + inc, 16);
      mp = p; my = y; mi = ni; ei = ni;
    end
    ez = sat(10 * (ei + longint'(z_offset) + slope), 16);
  endtask

  // Called at a falling edge with m_ready high
  task automatic push(string itag);
    longint ez, ei;
    s_valid = 1'b1;
    model(ez, ei);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    int_clr = 1'b0;
    chk("R1", m_valid, 1);
    chk(itag, m_integ, ei);
    chk("R8", m_z, ez);
  endtask

  task automatic idle_clear();
    loop_en = 1'b0; hold = 1'b0;
    push("R10");
    loop_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint ez_a, ei_a, ez_b, ei_b;
    void'($urandom(20240611));
    repeat (4) @(negedge clk);
    // R12: reset state
    chk("R12", m_valid, 0);
    chk("R12", s_ready, 1);
    chk("R12", m_z, 0);
    chk("R12", m_integ, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: first sample through the filter, error 1000, unity gain
    loop_en = 1'b1; kp = 8'd64; tc_sel = 4'd0;
    s_meas = 16'sd1000; setpoint = 16'sd0;
    push("R4");
    push("R4");

    // R2: positive error raises integrator and Z
    repeat (5) push("R5");
    chk("R2", (m_integ > 0) ? 1 : 0, 1);
    chk("R2", (m_z > 0) ? 1 : 0, 1);
    idle_clear();
    pol_inv = 1'b1;
    repeat (6) push("R5");
    chk("R2", (m_integ < 0) ? 1 : 0, 1);
    pol_inv = 1'b0;

    // R3: zero proportional gain
    idle_clear();
    kp = 8'd0;
    repeat (4) push("R3");
    chk("R3", m_integ, 0);

    // R5: time-constant clamp, code 15 acts as 10
    idle_clear();
    kp = 8'd134; tc_sel = 4'd15; s_meas = 16'sd20000;
    repeat (8) push("R5");

    // R6: saturation both ways
    idle_clear();
    kp = 8'd255; tc_sel = 4'd0; s_meas = 16'sd32767; setpoint = -16'sd32768;
    repeat (60) push("R6");
    chk("R6", m_integ, 32767);
    s_meas = -16'sd32768; setpoint = 16'sd32767;
    repeat (120) push("R6");
    chk("R6", m_integ, -32768);

    // R9: hold with large error
    hold = 1'b1;
    repeat (3) push("R9");
    chk("R9", m_integ, -32768);
    hold = 1'b0;

    // R11: clear during loop
    int_clr = 1'b1;
    push("R11");
    chk("R11", m_integ, 0);

    // R7 and R8 with loop open
    loop_en = 1'b0; setpoint = 16'sd0; s_meas = 16'sd0;
    slope_kx = 16'sd4096; scan_x = 16'sd100; slope_ky = -16'sd2048; scan_y = 16'sd50;
    push("R10");
    chk("R7", m_z, 750);
    slope_kx = 16'sd1; scan_x = 16'sd1; slope_ky = 16'sd0;
    push("R10");
    chk("R7", m_z, 0);
    slope_kx = -16'sd1;
    push("R10");
    chk("R7", m_z, -10);
    slope_kx = 16'sd0; z_offset = 16'sd30000;
    push("R10");
    chk("R8", m_z, 32767);
    z_offset = -16'sd30000;
    push("R10");
    chk("R8", m_z, -32768);
    z_offset = 16'sd0;

    // R1: back-pressure
    loop_en = 1'b1; kp = 8'd100; tc_sel = 4'd2; s_meas = 16'sd500;
    @(negedge clk);
    m_ready = 1'b0;
    s_valid = 1'b1;
    model(ez_a, ei_a);
    @(negedge clk);
    chk("R1", m_valid, 1);
    chk("R1", m_z, ez_a);
    s_meas = 16'sd1500; z_offset = 16'sd7;
    model(ez_b, ei_b);
    for (int k = 0; k < 3; k++) begin
      chk("R1", s_ready, 0);
      @(negedge clk);
      chk("R1", m_z, ez_a);
      chk("R1", m_integ, ei_a);
    end
    m_ready = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    chk("R1", m_z, ez_b);
    chk("R1", m_integ, ei_b);
    z_offset = 16'sd0;

    // Random mix
    for (int n = 0; n < 400; n++) begin
      string t;
      int sp;
      sp = int'($urandom_range(0, 20000)) - 10000;
      setpoint = 16'(sp);
      s_meas = 16'(sp + int'($urandom_range(0, 6000)) - 3000);
      kp = 8'($urandom_range(0, 255));
      tc_sel = 4'($urandom_range(0, 15));
      pol_inv = ($urandom_range(0, 7) == 0);
      loop_en = ($urandom_range(0, 15) != 0);
      hold = ($urandom_range(0, 7) == 0);
      int_clr = ($urandom_range(0, 15) == 0);
      z_offset = 16'(int'($urandom_range(0, 4000)) - 2000);
      slope_kx = 16'($urandom_range(0, 65535));
      slope_ky = 16'($urandom_range(0, 65535));
      scan_x = 16'(int'($urandom_range(0, 2000)) - 1000);
      scan_y = 16'(int'($urandom_range(0, 2000)) - 1000);
      if (!loop_en) t = "R10";
      else if (int_clr) t = "R11";
      else if (hold) t = "R9";
      else t = "R5";
      push(t);
      if ($urandom_range(0, 9) == 0) @(negedge clk);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule